// File: doc/BRIEF.md
# Posted-Write Word-to-Halfword Bus Bridge

This block connects a 32-bit CPU request port to a 16-bit external parallel bus. Each CPU request turns into two external halfword transactions. The first transaction carries the upper half of the word at the request address with bit 0 forced to zero. The second carries the lower half at that address plus two. The address is never rounded down to a word boundary. A request at an address that is 2 modulo 4 therefore straddles two words, and a narrow read there sees the following halfword.

Writes are posted. The bridge latches the address and data and acknowledges the CPU one cycle after the request. It then raises a busy flag and runs both external writes in the background. While the flag is set:
- another write is acknowledged but discarded;
- a read to any address is acknowledged at once with the latched write word.

A read from idle blocks the CPU. The reply comes only after both halfwords have returned, and requests presented during that time are ignored. Requests flagged as cached are never answered. There is no access-size input: every access is treated as a full word. The external side uses a level request held until a single-cycle acknowledge. Read data is valid in the same cycle as that acknowledge.

Top module: `hw_bridge`

## Requirements
- R1: Every accepted CPU read or write produces exactly two external transactions, each completed by one `ext_ack_i` pulse. `ext_req_o` and `ext_addr_o` stay steady until that pulse.
- R2: The first external transaction uses `{cpu_addr_i[31:1],1'b0}` and carries data bits 31:16. The second uses that address plus 2 and carries bits 15:0.
- R3: The address is not aligned to 32 bits. A read at byte address 0x12 returns `{half@0x12, half@0x14}`, and a read at 0x13 returns the same value.
- R4: A write accepted from idle gives `cpu_ack_o` high for one cycle, in the cycle after the request. `busy_o` is high in that same cycle.
- R5: `busy_o` stays 1 until the acknowledge of the second external write. It is 0 in the following cycle.
- R6: A write presented while `busy_o` is 1 is acknowledged in the next cycle but reaches neither the external bus nor the latched data.
- R7: A read presented while `busy_o` is 1 is acknowledged in the next cycle, with `cpu_rdata_o` equal to the latched write word, whatever its address.
- R8: A request with `cpu_cached_i` high gets no acknowledge and starts no external transaction.
- R9: A read from idle is acknowledged once, in the cycle after the second external acknowledge. Requests presented before that reply are ignored: no acknowledge and no external effect.
- R10: The read reply is `{first halfword, second halfword}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Request strobe, one cycle |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_cached_i | input | 1 | Cached request flag (never served) |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Write word |
| cpu_ack_o | output | 1 | Reply strobe: write posted or read data valid |
| cpu_rdata_o | output | 32 | Read reply word |
| busy_o | output | 1 | Posted write in progress |
| ext_req_o | output | 1 | External transaction request, held until acknowledged |
| ext_we_o | output | 1 | External transaction direction |
| ext_addr_o | output | 32 | External halfword address |
| ext_wdata_o | output | 16 | External write halfword |
| ext_ack_i | input | 1 | External completion strobe |
| ext_rdata_i | input | 16 | External read halfword, valid with ext_ack_i |

## Verification
A behavioural model is compared with the outputs on every clock. The directed sequence covers these patterns:
- A write from idle, which separates posting from blocking and checks which half goes out first.
- A write and a read issued inside the busy window, which show that the overlapping write is dropped and that the read returns the pending word rather than bus data.
- Reads at addresses 0 and 2 modulo 4 and at an odd address, which separate true word alignment from the halfword-aligned straddle.
- Cached requests, and requests issued during a blocking read, which must leave the acknowledge and the external bus untouched.

// File: rtl/hw_bridge_pkg.sv
package hw_bridge_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WR_HI = 3'd1,
    PH_WR_LO = 3'd2,
    PH_RD_HI = 3'd3,
    PH_RD_LO = 3'd4
  } phase_e;
endpackage

// File: rtl/hw_bridge_ctrl.sv
module hw_bridge_ctrl
  import hw_bridge_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_ok_i,
  input  logic   we_i,
  input  logic   ext_ack_i,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (req_ok_i) phase_d = we_i ? PH_WR_HI : PH_RD_HI;
      PH_WR_HI: if (ext_ack_i) phase_d = PH_WR_LO;
      PH_WR_LO: if (ext_ack_i) phase_d = PH_IDLE;
      PH_RD_HI: if (ext_ack_i) phase_d = PH_RD_LO;
      PH_RD_LO: if (ext_ack_i) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/hw_bridge_latch.sv
module hw_bridge_latch
  import hw_bridge_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  localparam int unsigned HW = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_i,
  input  logic          req_ok_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] ext_addr_o,
  output logic [HW-1:0] ext_wdata_o,
  output logic [DW-1:0] held_data_o
);
  logic [AW-2:0] addr_q;
  logic [DW-1:0] data_q;
  logic          first_half;
  logic [AW-1:0] base_addr;

  // only accept new contents from idle; overlapping writes never land here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (phase_i == PH_IDLE && req_ok_i) begin
      addr_q <= addr_i[AW-1:1];
      if (we_i) data_q <= wdata_i;
    end
  end

  assign first_half  = (phase_i == PH_WR_HI) || (phase_i == PH_RD_HI);
  assign base_addr   = {addr_q, 1'b0};
  assign ext_addr_o  = first_half ? base_addr : base_addr + AW'(2);
  assign ext_wdata_o = first_half ? data_q[DW-1:HW] : data_q[HW-1:0];
  assign held_data_o = data_q;
endmodule

// File: rtl/hw_bridge_resp.sv
module hw_bridge_resp
  import hw_bridge_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned HW = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_i,
  input  logic          req_ok_i,
  input  logic          we_i,
  input  logic [DW-1:0] held_data_i,
  input  logic          ext_ack_i,
  input  logic [HW-1:0] ext_rdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o
);
  logic [HW-1:0] hi_q;
  logic          ack_q;
  logic [DW-1:0] rdata_q;
  logic          posting;

  assign posting = (phase_i == PH_WR_HI) || (phase_i == PH_WR_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= 1'b0;
      if (phase_i == PH_IDLE && req_ok_i && we_i) ack_q <= 1'b1;
      if (posting && req_ok_i) begin
        ack_q <= 1'b1;
        if (!we_i) rdata_q <= held_data_i;
      end
      if (phase_i == PH_RD_HI && ext_ack_i) hi_q <= ext_rdata_i;
      if (phase_i == PH_RD_LO && ext_ack_i) begin
        rdata_q <= {hi_q, ext_rdata_i};
        ack_q   <= 1'b1;
      end
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/hw_bridge.sv
module hw_bridge
  import hw_bridge_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  localparam int unsigned HW = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic          cpu_cached_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_ack_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          busy_o,
  output logic          ext_req_o,
  output logic          ext_we_o,
  output logic [AW-1:0] ext_addr_o,
  output logic [HW-1:0] ext_wdata_o,
  input  logic          ext_ack_i,
  input  logic [HW-1:0] ext_rdata_i
);
  phase_e        phase;
  logic          req_ok;
  logic [DW-1:0] held_data;

  // cached requests are left unanswered
  assign req_ok = cpu_req_i && !cpu_cached_i;

  hw_bridge_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_ok_i (req_ok),
    .we_i     (cpu_we_i),
    .ext_ack_i(ext_ack_i),
    .phase_o  (phase)
  );

  hw_bridge_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .req_ok_i   (req_ok),
    .we_i       (cpu_we_i),
    .addr_i     (cpu_addr_i),
    .wdata_i    (cpu_wdata_i),
    .ext_addr_o (ext_addr_o),
    .ext_wdata_o(ext_wdata_o),
    .held_data_o(held_data)
  );

  hw_bridge_resp #(.DW(DW)) u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .req_ok_i   (req_ok),
    .we_i       (cpu_we_i),
    .held_data_i(held_data),
    .ext_ack_i  (ext_ack_i),
    .ext_rdata_i(ext_rdata_i),
    .ack_o      (cpu_ack_o),
    .rdata_o    (cpu_rdata_o)
  );

  assign busy_o    = (phase == PH_WR_HI) || (phase == PH_WR_LO);
  assign ext_req_o = (phase != PH_IDLE);
  assign ext_we_o  = busy_o;
endmodule

// File: rtl/hw_bridge_chk.sv
module hw_bridge_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cpu_req_i,
  input logic          cpu_we_i,
  input logic          cpu_cached_i,
  input logic          cpu_ack_o,
  input logic          busy_o,
  input logic          ext_req_o,
  input logic          ext_we_o,
  input logic [AW-1:0] ext_addr_o,
  input logic          ext_ack_i
);
  AST_HALF_ADDR_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o |-> !ext_addr_o[0]); // R2

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_o && !ext_ack_i) |=> (ext_req_o && $stable(ext_addr_o))); // R1

  AST_POST_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && !cpu_cached_i && !ext_req_o) |=> (cpu_ack_o && busy_o)); // R4

  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(ext_ack_i)); // R5

  AST_BUSY_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cpu_req_i && !cpu_cached_i) |=> cpu_ack_o); // R7

  AST_CACHED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_req_o && cpu_req_i && cpu_cached_i) |=> (!cpu_ack_o && !ext_req_o)); // R8

  AST_READ_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_o && !ext_we_o) |-> !cpu_ack_o); // R9
endmodule

bind hw_bridge hw_bridge_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_cached_i(cpu_cached_i),
  .cpu_ack_o   (cpu_ack_o),
  .busy_o      (busy_o),
  .ext_req_o   (ext_req_o),
  .ext_we_o    (ext_we_o),
  .ext_addr_o  (ext_addr_o),
  .ext_ack_i   (ext_ack_i)
);

// File: tb/hw_bridge_tb.sv
`timescale 1ns/1ps
module hw_bridge_tb;
  localparam int LAT = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0, cpu_cached_i = 1'b0;
  logic [31:0] cpu_addr_i = '0, cpu_wdata_i = '0;
  logic        cpu_ack_o, busy_o, ext_req_o, ext_we_o;
  logic [31:0] cpu_rdata_o, ext_addr_o;
  logic [15:0] ext_wdata_o;
  logic        ext_ack_i = 1'b0;
  logic [15:0] ext_rdata_i = '0;

  int total = 0, bad = 0, cyc = 0, ext_acks = 0, cpu_acks = 0;

  always #2 clk_i = ~clk_i;

  hw_bridge u_dut (.*);

  // external device: fixed latency, halfword memory
  logic [15:0] mem [0:127];
  int dcnt = 0;
  initial for (int i = 0; i < 128; i++) mem[i] = 16'hA000 | 16'(i);
  always @(posedge clk_i) begin
    if (ext_ack_i) begin
      ext_ack_i <= 1'b0; dcnt <= 0;
    end else if (ext_req_o) begin
      if (dcnt == LAT - 1) begin
        ext_ack_i <= 1'b1; dcnt <= 0;
        if (ext_we_o) mem[ext_addr_o[7:1]] <= ext_wdata_o;
        else ext_rdata_i <= mem[ext_addr_o[7:1]];
      end else dcnt <= dcnt + 1;
    end
  end
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (ext_ack_i) ext_acks <= ext_acks + 1;
    if (cpu_ack_o) cpu_acks <= cpu_acks + 1;
  end

  // behavioural reference: phase 0 idle, 1/2 write halves, 3/4 read halves
  int          m_ph = 0;
  logic [31:0] m_addr = '0, m_data = '0, m_rdata = '0;
  logic [15:0] m_hi = '0;
  logic        m_ack = 1'b0;
  always @(posedge clk_i) begin
    if (rst_ni) begin
      m_ack <= 1'b0;
      if (m_ph == 0 && cpu_req_i && !cpu_cached_i) begin
        m_addr <= cpu_addr_i & 32'hFFFF_FFFE;
        if (cpu_we_i) begin m_data <= cpu_wdata_i; m_ack <= 1'b1; m_ph <= 1; end
        else m_ph <= 3;
      end else if ((m_ph == 1 || m_ph == 2) && cpu_req_i && !cpu_cached_i) begin
        m_ack <= 1'b1;
        if (!cpu_we_i) m_rdata <= m_data;
      end
      if (ext_ack_i) begin
        case (m_ph)
          1: m_ph <= 2;
          2: m_ph <= 0;
          3: begin m_hi <= ext_rdata_i; m_ph <= 4; end
          4: begin m_rdata <= {m_hi, ext_rdata_i}; m_ack <= 1'b1; m_ph <= 0; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  logic [31:0] m_eaddr;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      m_eaddr = (m_ph == 1 || m_ph == 3) ? m_addr : m_addr + 32'd2;
      chk("R5 model busy", 32'(busy_o), 32'(m_ph == 1 || m_ph == 2));
      chk("R1 model ext_req", 32'(ext_req_o), 32'(m_ph != 0));
      chk("R4 model cpu_ack", 32'(cpu_ack_o), 32'(m_ack));
      if (m_ph != 0) chk("R2 model ext_addr", ext_addr_o, m_eaddr);
      if (m_ph == 1) chk("R2 model hi wdata", 32'(ext_wdata_o), 32'(m_data[31:16]));
      if (m_ph == 2) chk("R2 model lo wdata", 32'(ext_wdata_o), 32'(m_data[15:0]));
      if (m_ack) chk("R10 model rdata", cpu_rdata_o, m_rdata);
    end
  end

  task automatic issue(input logic we, input logic cached, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_cached_i = cached; cpu_addr_i = a; cpu_wdata_i = d;
    @(negedge clk_i);
    cpu_req_i = 1'b0; cpu_cached_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && ext_req_o; i++) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d);
    issue(1'b0, 1'b0, a, 32'h0);
    for (int i = 0; i < 200 && !cpu_ack_o; i++) @(negedge clk_i);
    d = cpu_rdata_o;
  endtask

  initial begin
    logic [31:0] rd;
    int e0, a0;
    repeat (3) @(negedge clk_i);
    chk("R4 reset ack", 32'(cpu_ack_o), 32'h0);
    chk("R5 reset busy", 32'(busy_o), 32'h0);
    chk("R1 reset ext_req", 32'(ext_req_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // posted write, then overlapping write and read inside the busy window
    e0 = ext_acks;
    issue(1'b1, 1'b0, 32'h10, 32'hAABB_CCDD);
    chk("R4 posted ack", 32'(cpu_ack_o), 32'h1);
    chk("R4 busy with ack", 32'(busy_o), 32'h1);
    issue(1'b1, 1'b0, 32'h20, 32'h1111_2222);
    chk("R6 dropped write acked", 32'(cpu_ack_o), 32'h1);
    issue(1'b0, 1'b0, 32'h40, 32'h0);
    chk("R7 busy read ack", 32'(cpu_ack_o), 32'h1);
    chk("R7 busy read data", cpu_rdata_o, 32'hAABB_CCDD);
    for (int i = 0; i < 200 && busy_o; i++) @(negedge clk_i);
    chk("R5 two writes done at busy fall", 32'(ext_acks - e0), 32'd2);
    chk("R2 hi half at base", 32'(mem[8]), 32'h0000_AABB);
    chk("R2 lo half at base+2", 32'(mem[9]), 32'h0000_CCDD);
    chk("R6 dropped write 0x20", 32'(mem[16]), 32'h0000_A010);
    chk("R6 dropped write 0x22", 32'(mem[17]), 32'h0000_A011);
    wait_idle();

    // reads: aligned, straddling, odd
    e0 = ext_acks;
    do_read(32'h0, rd);
    chk("R10 aligned read", rd, 32'hA000_A001);
    chk("R1 two halves per read", 32'(ext_acks - e0), 32'd2);
    wait_idle();
    do_read(32'h12, rd);
    chk("R3 straddle read 0x12", rd, 32'hCCDD_A00A);
    wait_idle();
    do_read(32'h13, rd);
    chk("R3 odd read 0x13", rd, 32'hCCDD_A00A);
    wait_idle();

    // cached requests ignored
    e0 = ext_acks; a0 = cpu_acks;
    issue(1'b0, 1'b1, 32'h4, 32'h0);
    issue(1'b1, 1'b1, 32'h30, 32'h5555_6666);
    repeat (10) @(negedge clk_i);
    chk("R8 no ack for cached", 32'(cpu_acks - a0), 32'h0);
    chk("R8 no ext for cached", 32'(ext_acks - e0), 32'h0);
    chk("R8 cached write no store", 32'(mem[24]), 32'h0000_A018);

    // blocking read ignores requests until reply
    a0 = cpu_acks; e0 = ext_acks;
    issue(1'b0, 1'b0, 32'h4, 32'h0);
    issue(1'b1, 1'b0, 32'h30, 32'h7777_8888);
    issue(1'b0, 1'b0, 32'h40, 32'h0);
    for (int i = 0; i < 200 && !cpu_ack_o; i++) @(negedge clk_i);
    chk("R9 blocking read data", cpu_rdata_o, 32'hA002_A003);
    chk("R9 reply after both halves", 32'(ext_acks - e0), 32'd2);
    repeat (12) @(negedge clk_i);
    chk("R9 single ack", 32'(cpu_acks - a0), 32'd1);
    chk("R9 ignored write", 32'(mem[24]), 32'h0000_A018);
    chk("R9 bus idle", 32'(ext_req_o), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL R1 watchdog act=%0d exp=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule